// File: doc/BRIEF.md
# 8051 Data Memory Access Router

This block sits between an 8051-style core and its data memories. For every data access it decides which store answers: the lower internal RAM, the upper internal RAM, the special function register file, the on-chip expanded RAM, or the external bus. It decides from the access kind, the address and one bit of a small auxiliary control register. The choice is combinational, in the same cycle as the request. When the external bus is chosen, the block runs a fixed bus cycle on its own state machine. That cycle drives the multiplexed low address/data port, the upper address port, the read and write strobes and the address latch enable (ALE).

The auxiliary register holds three bits. The first suppresses ALE outside external cycles. The second sends low external-data addresses to the on-chip expanded RAM instead of the bus. The third is a low-voltage enable that is only passed out on a port. The core must not issue a new access while `xbus_busy` is high.

Bus state machine states:
- `XB_IDLE`: no external cycle is running.
- `XB_ADDR`: the address phase, `ADDR_CLKS` clocks long. ALE is high in its first clock.
- `XB_STRB`: the strobe phase, `STRB_CLKS` clocks long.
- `XB_RECOV`: the recovery phase, `REC_CLKS` clocks long.

Transitions:
- IDLE→ADDR: an accepted access that targets the bus.
- ADDR→STRB, STRB→RECOV and RECOV→IDLE: when the phase counter reaches zero.

Top module: `dmr_router`

## Requirements
- R1: A direct (`acc_kind`=00) or indirect (`acc_kind`=01) access to addresses 00H–7FH asserts only `sel_lo`.
- R2: For addresses 80H–FFH, an indirect access asserts only `sel_hi` and a direct access asserts only `sel_sfr`.
- R3: With the expanded-RAM bit (aux bit 1) at 0, an 8-bit-pointer MOVX (`acc_kind`=10) to any address asserts only `sel_xram`. A 16-bit-pointer MOVX (`acc_kind`=11) whose address is 0000H–00FFH does the same.
- R4: An expanded-RAM access starts no bus cycle. `ext_rd_n` and `ext_wr_n` stay high and `ext_lo_oe` stays low.
- R5: A 16-bit-pointer MOVX to 0100H–FFFFH asserts only `sel_ext`, whatever the aux register holds. It then runs a bus cycle that starts on the next clock:
  - clocks 1–2: the low address byte is on `ext_lo_out` with `ext_lo_oe` high, and the high byte is on `ext_hi_out` with `ext_hi_oe` high;
  - clocks 3–5: the strobe is low (`ext_wr_n` for a write, which drives `acc_wdata` on the low port; `ext_rd_n` for a read, which releases the low port);
  - clock 6: both strobes are high;
  - from clock 7: `xbus_busy` is low.
- R6: With aux bit 1 at 1, every MOVX asserts only `sel_ext`. An 8-bit-pointer MOVX drives only the low address byte and keeps `ext_hi_oe` low.
- R7: The aux register resets to 0000_0110b: bit 0 is ALE suppress, bit 1 is the expanded-RAM bit, bit 2 is the low-voltage enable. Writes to bits 7–3 are ignored and those bits read 0.
- R8: With aux bit 0 at 0, ALE is high for one clock in every 6, even when the bus is idle.
- R9: With aux bit 0 at 1, ALE is high only in the first address-phase clock of a bus cycle, or while `movc_ext` is high.
- R10: At most one select is high. None is high without `acc_rd` or `acc_wr`, and none is high while `xbus_busy` is high. `acc_wr` marks a write and takes precedence over `acc_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_kind | input | 2 | 00 direct, 01 indirect, 10 MOVX 8-bit pointer, 11 MOVX 16-bit pointer |
| acc_addr | input | 16 | Access address |
| acc_rd | input | 1 | Read request |
| acc_wr | input | 1 | Write request |
| acc_wdata | input | 8 | Write data for external writes |
| movc_ext | input | 1 | Core is fetching code externally (enables ALE) |
| aux_we | input | 1 | Aux register write enable |
| aux_wdata | input | 8 | Aux register write data |
| aux_rdata | output | 8 | Aux register readback |
| aux_lowvolt | output | 1 | Low-voltage converter enable (aux bit 2) |
| sel_lo | output | 1 | Lower RAM select |
| sel_hi | output | 1 | Upper RAM select |
| sel_sfr | output | 1 | SFR file select |
| sel_xram | output | 1 | On-chip expanded RAM select |
| sel_ext | output | 1 | External bus select |
| xbus_busy | output | 1 | External cycle in progress |
| ext_ale | output | 1 | Address latch enable |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |
| ext_lo_oe | output | 1 | Low port drive enable |
| ext_lo_out | output | 8 | Low port value (address, then write data) |
| ext_hi_oe | output | 1 | Upper port drive enable |
| ext_hi_out | output | 8 | Upper port value (high address byte) |

## Verification
The hardest situation to reach is a request that arrives while a bus cycle is in flight, because a well-behaved core never does that. The bench starts a 16-bit external write and then, in the strobe phase, drives a competing direct request. It checks that no select rises and that the running cycle keeps its strobe and data. The ALE cadence is covered with the suppression bit set and clear: the bench counts pulses over a window of idle clocks, and the spacing between them, instead of checking single clocks.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
    typedef enum logic [1:0] {
        ACC_DIRECT   = 2'b00,
        ACC_INDIRECT = 2'b01,
        ACC_MOVX8    = 2'b10,
        ACC_MOVX16   = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        XB_IDLE,
        XB_ADDR,
        XB_STRB,
        XB_RECOV
    } xb_state_e;

    typedef struct packed {
        logic lowvolt;
        logic xram_off;
        logic ale_off;
    } aux_t;

    typedef struct packed {
        logic lo;
        logic hi;
        logic sfr;
        logic xram;
        logic ext;
    } sel_t;
endpackage

// File: rtl/dmr_aux_reg.sv
module dmr_aux_reg #(
    parameter int DATA_W = 8,
    parameter int AUX_W  = 3,
    parameter logic [AUX_W-1:0] RST_VAL = 3'b110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output dmr_pkg::aux_t     aux
);
    localparam int PAD_W = DATA_W - AUX_W;

    logic [AUX_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= RST_VAL;
        else if (we) q <= wdata[AUX_W-1:0];
    end

    assign rdata = {{PAD_W{1'b0}}, q};
    assign aux   = dmr_pkg::aux_t'(q);
endmodule

// File: rtl/dmr_route.sv
module dmr_route #(
    parameter int ADDR_W = 16
) (
    input  logic              valid,
    input  logic              busy,
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic              xram_off,
    output dmr_pkg::sel_t     sel
);
    import dmr_pkg::*;

    localparam int HI_W = ADDR_W - 8;

    logic page0;
    assign page0 = (addr[ADDR_W-1:8] == {HI_W{1'b0}});

    always_comb begin
        sel = '0;
        if (valid && !busy) begin
            unique case (acc_kind_e'(kind))
                ACC_DIRECT:   if (addr[7]) sel.sfr = 1'b1; else sel.lo = 1'b1;
                ACC_INDIRECT: if (addr[7]) sel.hi  = 1'b1; else sel.lo = 1'b1;
                ACC_MOVX8:    if (xram_off) sel.ext = 1'b1; else sel.xram = 1'b1;
                ACC_MOVX16:   if (xram_off || !page0) sel.ext = 1'b1;
                              else sel.xram = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/dmr_ale_gen.sv
module dmr_ale_gen #(
    parameter int PERIOD = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic ale_off,
    input  logic in_addr,
    input  logic movc_ext,
    output logic ale
);
    localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              phase <= '0;
        else if (restart)        phase <= '0;
        else if (phase == LAST)  phase <= '0;
        else                     phase <= phase + 1'b1;
    end

    assign ale = (phase == '0) && (!ale_off || in_addr || movc_ext);
endmodule

// File: rtl/dmr_xbus_fsm.sv
module dmr_xbus_fsm #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int ADDR_CLKS = 2,
    parameter int STRB_CLKS = 3,
    parameter int REC_CLKS  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              in_addr,
    output logic              rd_n,
    output logic              wr_n,
    output logic              lo_oe,
    output logic [DATA_W-1:0] lo_out,
    output logic              hi_oe,
    output logic [DATA_W-1:0] hi_out
);
    import dmr_pkg::*;

    localparam int MAXC  = (ADDR_CLKS > STRB_CLKS) ?
                           ((ADDR_CLKS > REC_CLKS) ? ADDR_CLKS : REC_CLKS) :
                           ((STRB_CLKS > REC_CLKS) ? STRB_CLKS : REC_CLKS);
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

    xb_state_e         state, state_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q, wide_q;

    always_comb begin
        state_nx = state;
        cnt_nx   = (cnt == '0) ? '0 : cnt - 1'b1;
        unique case (state)
            XB_IDLE:  if (start) begin
                          state_nx = XB_ADDR;
                          cnt_nx   = CNT_W'(ADDR_CLKS - 1);
                      end
            XB_ADDR:  if (cnt == '0) begin
                          state_nx = XB_STRB;
                          cnt_nx   = CNT_W'(STRB_CLKS - 1);
                      end
            XB_STRB:  if (cnt == '0) begin
                          state_nx = XB_RECOV;
                          cnt_nx   = CNT_W'(REC_CLKS - 1);
                      end
            XB_RECOV: if (cnt == '0) state_nx = XB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= XB_IDLE;
            cnt     <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            wide_q  <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            if (state == XB_IDLE && start) begin
                addr_q  <= addr;
                wdata_q <= wdata;
                we_q    <= is_write;
                wide_q  <= wide;
            end
        end
    end

    always_comb begin
        busy    = 1'b1;
        in_addr = 1'b0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        lo_oe   = 1'b0;
        lo_out  = '0;
        hi_oe   = wide_q;
        hi_out  = wide_q ? addr_q[ADDR_W-1:ADDR_W-DATA_W] : '0;
        unique case (state)
            XB_IDLE: begin
                busy   = 1'b0;
                hi_oe  = 1'b0;
                hi_out = '0;
            end
            XB_ADDR: begin
                in_addr = 1'b1;
                lo_oe   = 1'b1;
                lo_out  = addr_q[DATA_W-1:0];
            end
            XB_STRB: begin
                rd_n   = we_q;
                wr_n   = !we_q;
                lo_oe  = we_q;
                lo_out = we_q ? wdata_q : '0;
            end
            XB_RECOV: begin
                lo_oe  = we_q;
                lo_out = we_q ? wdata_q : '0;
            end
        endcase
    end
endmodule

// File: rtl/dmr_router.sv
module dmr_router #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int ALE_PER   = 6,
    parameter int ADDR_CLKS = 2,
    parameter int STRB_CLKS = 3,
    parameter int REC_CLKS  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              movc_ext,
    input  logic              aux_we,
    input  logic [DATA_W-1:0] aux_wdata,
    output logic [DATA_W-1:0] aux_rdata,
    output logic              aux_lowvolt,
    output logic              sel_lo,
    output logic              sel_hi,
    output logic              sel_sfr,
    output logic              sel_xram,
    output logic              sel_ext,
    output logic              xbus_busy,
    output logic              ext_ale,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic              ext_lo_oe,
    output logic [DATA_W-1:0] ext_lo_out,
    output logic              ext_hi_oe,
    output logic [DATA_W-1:0] ext_hi_out
);
    import dmr_pkg::*;

    aux_t aux;
    sel_t sel;
    logic in_addr;

    dmr_aux_reg #(.DATA_W(DATA_W)) u_aux (
        .clk(clk), .rst_n(rst_n), .we(aux_we), .wdata(aux_wdata),
        .rdata(aux_rdata), .aux(aux)
    );

    dmr_route #(.ADDR_W(ADDR_W)) u_route (
        .valid(acc_rd || acc_wr), .busy(xbus_busy), .kind(acc_kind),
        .addr(acc_addr), .xram_off(aux.xram_off), .sel(sel)
    );

    dmr_xbus_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_CLKS(ADDR_CLKS),
        .STRB_CLKS(STRB_CLKS), .REC_CLKS(REC_CLKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(sel.ext),
        .wide(acc_kind == ACC_MOVX16), .is_write(acc_wr),
        .addr(acc_addr), .wdata(acc_wdata), .busy(xbus_busy),
        .in_addr(in_addr), .rd_n(ext_rd_n), .wr_n(ext_wr_n),
        .lo_oe(ext_lo_oe), .lo_out(ext_lo_out),
        .hi_oe(ext_hi_oe), .hi_out(ext_hi_out)
    );

    dmr_ale_gen #(.PERIOD(ALE_PER)) u_ale (
        .clk(clk), .rst_n(rst_n), .restart(sel.ext), .ale_off(aux.ale_off),
        .in_addr(in_addr), .movc_ext(movc_ext), .ale(ext_ale)
    );

    assign aux_lowvolt = aux.lowvolt;
    assign sel_lo      = sel.lo;
    assign sel_hi      = sel.hi;
    assign sel_sfr     = sel.sfr;
    assign sel_xram    = sel.xram;
    assign sel_ext     = sel.ext;
endmodule

// File: rtl/dmr_checker.sv
module dmr_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        acc_kind,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_rd,
    input logic              acc_wr,
    input logic              movc_ext,
    input logic [DATA_W-1:0] aux_rdata,
    input logic              sel_lo,
    input logic              sel_hi,
    input logic              sel_sfr,
    input logic              sel_xram,
    input logic              sel_ext,
    input logic              xbus_busy,
    input logic              ext_ale,
    input logic              ext_rd_n,
    input logic              ext_wr_n,
    input logic              ext_lo_oe,
    input logic              ext_hi_oe
);
    assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_lo, sel_hi, sel_sfr, sel_xram, sel_ext}));

    assert_no_req_no_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rd && !acc_wr) |-> !(sel_lo || sel_hi || sel_sfr || sel_xram || sel_ext));

    assert_xram_quiet_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_xram |=> (ext_rd_n && ext_wr_n && !ext_lo_oe));

    assert_ext_starts_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ext |=> xbus_busy);

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    assert_idle_bus_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !xbus_busy |-> (ext_rd_n && ext_wr_n && !ext_lo_oe && !ext_hi_oe));

    assert_ale_suppressed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_rdata[0] && !xbus_busy && !movc_ext) |-> !ext_ale);

    assert_aux_pad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        aux_rdata[DATA_W-1:3] == '0);

    assert_direct_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_rd || acc_wr) && !xbus_busy && acc_kind[1] == 1'b0 && !acc_addr[7]) |-> sel_lo);
endmodule

bind dmr_router dmr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dmr_router.sv
`timescale 1ns/1ps
module tb_dmr_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_kind = 2'b00;
    logic [15:0] acc_addr = '0;
    logic        acc_rd = 1'b0, acc_wr = 1'b0;
    logic [7:0]  acc_wdata = '0;
    logic        movc_ext = 1'b0;
    logic        aux_we = 1'b0;
    logic [7:0]  aux_wdata = '0;
    logic [7:0]  aux_rdata;
    logic        aux_lowvolt;
    logic        sel_lo, sel_hi, sel_sfr, sel_xram, sel_ext, xbus_busy;
    logic        ext_ale, ext_rd_n, ext_wr_n, ext_lo_oe, ext_hi_oe;
    logic [7:0]  ext_lo_out, ext_hi_out;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dmr_router dut (.*);

    function automatic logic [4:0] sels();
        return {sel_lo, sel_hi, sel_sfr, sel_xram, sel_ext};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic aux_write(input logic [7:0] v);
        @(negedge clk); aux_we = 1'b1; aux_wdata = v;
        @(negedge clk); aux_we = 1'b0;
    endtask

    // one-cycle request that must not start a bus cycle
    task automatic probe(input logic [1:0] k, input logic [15:0] a,
                         input logic [4:0] exp, input string req);
        @(negedge clk);
        acc_kind = k; acc_addr = a; acc_rd = 1'b1;
        #1 check(sels() == exp, req, sels(), exp);
        @(negedge clk);
        acc_rd = 1'b0;
        if (exp == 5'b00010)
            check(ext_rd_n && ext_wr_n && !ext_lo_oe && !xbus_busy, "R4",
                  {ext_rd_n, ext_wr_n, ext_lo_oe, xbus_busy}, 4'b1100);
    endtask

    task automatic t_reset();
        check(aux_rdata == 8'h06, "R7", aux_rdata, 8'h06);
        check(aux_lowvolt == 1'b1, "R7", aux_lowvolt, 1);
        check(sels() == 5'b0 && !xbus_busy, "R10", sels(), 0);
    endtask

    task automatic t_lower_upper();
        probe(2'b00, 16'h0012, 5'b10000, "R1");
        probe(2'b01, 16'h007F, 5'b10000, "R1");
        probe(2'b00, 16'h00A0, 5'b00100, "R2");
        probe(2'b01, 16'h00A0, 5'b01000, "R2");
        probe(2'b01, 16'h0080, 5'b01000, "R2");
    endtask

    task automatic t_aux();
        aux_write(8'hF8);
        check(aux_rdata == 8'h00, "R7", aux_rdata, 8'h00);
        aux_write(8'hFF);
        check(aux_rdata == 8'h07, "R7", aux_rdata, 8'h07);
        aux_write(8'h04);
    endtask

    task automatic t_xram();
        probe(2'b10, 16'h00A0, 5'b00010, "R3");
        probe(2'b11, 16'h00FF, 5'b00010, "R3");
        probe(2'b11, 16'h0000, 5'b00010, "R3");
    endtask

    // full external cycle; optional competing request in strobe phase
    task automatic ext_cycle(input logic [1:0] k, input logic [15:0] a, input bit we,
                             input logic [7:0] wd, input bit wide, input string req);
        @(negedge clk);
        acc_kind = k; acc_addr = a; acc_wdata = wd;
        acc_wr = we; acc_rd = !we;
        #1 check(sels() == 5'b00001, req, sels(), 5'b00001);
        @(negedge clk); acc_rd = 1'b0; acc_wr = 1'b0;
        for (int c = 1; c <= 7; c++) begin
            if (c <= 2) begin
                check(ext_lo_oe && ext_lo_out == a[7:0], req, ext_lo_out, a[7:0]);
                check(ext_ale == (c == 1), req, ext_ale, (c == 1));
            end else if (c <= 5) begin
                check(ext_wr_n == !we && ext_rd_n == we, req, {ext_rd_n, ext_wr_n}, {we, !we});
                check(ext_lo_oe == we && (!we || ext_lo_out == wd), req, ext_lo_out, wd);
                if (c == 3) begin
                    acc_kind = 2'b00; acc_addr = 16'h0010; acc_rd = 1'b1;
                    #1 check(sels() == 5'b0, "R10", sels(), 0);
                    acc_rd = 1'b0;
                end
            end else if (c == 6) begin
                check(ext_rd_n && ext_wr_n && xbus_busy, req, {ext_rd_n, ext_wr_n, xbus_busy}, 3'b111);
            end else begin
                check(!xbus_busy && !ext_hi_oe, req, xbus_busy, 0);
            end
            if (c <= 6)
                check(ext_hi_oe == wide && (!wide || ext_hi_out == a[15:8]),
                      wide ? "R5" : "R6", {ext_hi_oe, ext_hi_out}, {wide, a[15:8]});
            if (c < 7) @(negedge clk);
        end
    endtask

    task automatic count_ale(output int cnt, output int gap);
        int first = -1;
        cnt = 0; gap = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (ext_ale) begin
                cnt++;
                if (first < 0) first = i; else if (gap == 0) gap = i - first;
            end
        end
    endtask

    task automatic t_ale();
        int cnt, gap;
        aux_write(8'h06);
        count_ale(cnt, gap);
        check(cnt == 2 && gap == 6, "R8", {cnt[15:0], gap[15:0]}, {16'd2, 16'd6});
        aux_write(8'h07);
        count_ale(cnt, gap);
        check(cnt == 0, "R9", cnt, 0);
        movc_ext = 1'b1;
        count_ale(cnt, gap);
        check(cnt == 2, "R9", cnt, 2);
        movc_ext = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lower_upper();
        ext_cycle(2'b10, 16'h0034, 1'b0, 8'h00, 1'b0, "R6");
        ext_cycle(2'b11, 16'h0056, 1'b1, 8'h5A, 1'b1, "R6");
        t_aux();
        t_xram();
        ext_cycle(2'b11, 16'h1234, 1'b1, 8'hC3, 1'b1, "R5");
        ext_cycle(2'b11, 16'hFF01, 1'b0, 8'h00, 1'b1, "R5");
        t_ale();
        ext_cycle(2'b11, 16'h0100, 1'b0, 8'h00, 1'b1, "R9");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule